// File: doc/BRIEF.md
# Doubled-Pixel VGA Scan-Out Engine

This block drives a 640×480, 60 Hz monitor from a 320×240 picture held in one read port of a dual-port frame memory. It runs on the system clock and moves one screen pixel each time the 25 MHz pixel enable pulses. It produces active-low horizontal and vertical sync, a visible-area flag, the frame-memory read address and 12-bit RGB (4 bits each of red, green and blue). Each stored pixel is repeated over two columns and two rows, so the quarter-size picture fills the whole screen.

Two copies of one phase state machine handle the horizontal and vertical axes. Each has four states: VISIBLE, FRONT (front porch), PULSE (sync pulse) and BACK (back porch). There are four transitions, each taken on the last count of a phase: VISIBLE→FRONT, FRONT→PULSE, PULSE→BACK and BACK→VISIBLE. The horizontal machine steps on every pixel enable. The vertical machine steps only when the horizontal machine takes its BACK→VISIBLE transition. A registered output stage lags the scan position by one pixel period. This lines the syncs and the visible flag up with data from a memory that has one clock of read latency. The display-mode switch gates the picture: when it is low the screen is black but the syncs keep running.

The pixel enable must have at least one idle clock between pulses. This gives the memory a clock edge to return the word for the current address before the output stage captures it.

Top module: `vga_upscale_scanout`

## Requirements
- R1: While reset is active, and right after it, hsync_n and vsync_n are 1, video_on is 0, rgb_out is 0 and rd_addr is 0.
- R2: The scan position and all outputs change only at clock edges where pix_en is 1. They hold their values on every other clock.
- R3: A line lasts H_VIS+H_FRONT+H_SYNC+H_BACK enables (default 640+16+96+48 = 800). hsync_n is 0 for screen columns H_VIS+H_FRONT up to H_VIS+H_FRONT+H_SYNC-1 (default 656..751), with a one-enable lag.
- R4: A frame lasts V_VIS+V_FRONT+V_SYNC+V_BACK lines (default 480+10+2+33 = 525). vsync_n is 0 throughout lines V_VIS+V_FRONT up to V_VIS+V_FRONT+V_SYNC-1 (default 490..491), with a one-enable lag.
- R5: video_on is 1 exactly for column < H_VIS and line < V_VIS, with a one-enable lag.
- R6: Inside the visible area, rd_addr = (line>>1)*(H_VIS/2) + (column>>1) for the current, non-lagged position. Outside the visible area rd_addr is 0.
- R7: When video_on rises for a position, rgb_out holds the word returned for that position's address: bits 11:8 red, 7:4 green and 3:0 blue, taken from rd_data one enable after the address was issued.
- R8: rgb_out is 0 for any position scanned while show_mode was 0, and for any position outside the visible area. The syncs and video_on are not affected by show_mode.
- R9: After the last enable of the final line's back porch, the scan returns to column 0, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate enable, one clock wide, at least one idle clock between pulses |
| show_mode | input | 1 | 1 = display the stored picture, 0 = black screen |
| rd_addr | output | ADDR_W | Frame-memory read address (17 bits by default) |
| rd_data | input | PIX_W | Frame-memory read data, one clock after rd_addr |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video_on | output | 1 | Visible-area flag, aligned with rgb_out |
| rgb_out | output | PIX_W | Pixel colour, {red, green, blue} |

## Verification
The situations hardest to reach are the vertical events: the sync lines, the last line of a frame, and the wrap back to line 0. At full geometry each frame takes 420,000 enables. The bench therefore builds the block with a reduced geometry that keeps all four phases on both axes, so several whole frames fit in a short run. Enable gaps and show_mode toggles are drawn from a seeded random source, and a reset is applied mid-frame. The frame memory is modelled as a computed function of the address, so every pixel has a distinct, predictable colour.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    typedef enum logic [1:0] {
        PH_VISIBLE = 2'd0,
        PH_FRONT   = 2'd1,
        PH_PULSE   = 2'd2,
        PH_BACK    = 2'd3
    } scan_phase_e;

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vga_axis_fsm.sv
module vga_axis_fsm
    import vga_scan_pkg::*;
#(
    parameter int unsigned VIS   = 640,
    parameter int unsigned FRONT = 16,
    parameter int unsigned PULSE = 96,
    parameter int unsigned BACK  = 48,
    localparam int unsigned TOTAL = VIS + FRONT + PULSE + BACK,
    localparam int unsigned CW    = width_for(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] pos,
    output logic          in_vis,
    output logic          in_pulse,
    output logic          wrap
);

    localparam logic [CW-1:0] VIS_END   = CW'(VIS - 1);
    localparam logic [CW-1:0] FRONT_END = CW'(FRONT - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(PULSE - 1);
    localparam logic [CW-1:0] BACK_END  = CW'(BACK - 1);

    scan_phase_e   phase_q, phase_n;
    logic [CW-1:0] pos_q, pos_n, end_pos;
    logic          at_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_VISIBLE;
            pos_q   <= '0;
        end else if (step) begin
            phase_q <= phase_n;
            pos_q   <= pos_n;
        end
    end

    // next state
    always_comb begin
        unique case (phase_q)
            PH_VISIBLE: end_pos = VIS_END;
            PH_FRONT:   end_pos = FRONT_END;
            PH_PULSE:   end_pos = PULSE_END;
            PH_BACK:    end_pos = BACK_END;
        endcase
        at_end  = (pos_q == end_pos);
        phase_n = phase_q;
        pos_n   = pos_q + 1'b1;
        if (at_end) begin
            pos_n = '0;
            unique case (phase_q)
                PH_VISIBLE: phase_n = PH_FRONT;
                PH_FRONT:   phase_n = PH_PULSE;
                PH_PULSE:   phase_n = PH_BACK;
                PH_BACK:    phase_n = PH_VISIBLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pos      = pos_q;
        in_vis   = (phase_q == PH_VISIBLE);
        in_pulse = (phase_q == PH_PULSE);
        wrap     = step && at_end && (phase_q == PH_BACK);
    end

    a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(phase_q) && $stable(pos_q));

    a_r9_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (phase_q == PH_VISIBLE) && (pos_q == '0));

    a_r3_pulse_follows_front: assert property (@(posedge clk) disable iff (!rst_n)
        step && (phase_q == PH_FRONT) && at_end |=> phase_q == PH_PULSE);

endmodule

// File: rtl/vga_addr_gen.sv
module vga_addr_gen #(
    parameter int unsigned SRC_W  = 320,
    parameter int unsigned X_W    = 10,
    parameter int unsigned Y_W    = 10,
    parameter int unsigned ADDR_W = 17
) (
    input  logic              vis,
    input  logic [X_W-1:0]    col,
    input  logic [Y_W-1:0]    row,
    output logic [ADDR_W-1:0] addr
);

    logic [31:0] linear;

    always_comb begin
        linear = 32'(row >> 1) * 32'(SRC_W) + 32'(col >> 1);
        addr   = vis ? ADDR_W'(linear) : '0;
    end

endmodule

// File: rtl/vga_out_stage.sv
module vga_out_stage #(
    parameter int unsigned PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             show,
    input  logic             vis,
    input  logic             hpulse,
    input  logic             vpulse,
    input  logic [PIX_W-1:0] pix_in,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             video_on,
    output logic [PIX_W-1:0] rgb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_n  <= 1'b1;
            vsync_n  <= 1'b1;
            video_on <= 1'b0;
            rgb      <= '0;
        end else if (pix_en) begin
            hsync_n  <= !hpulse;
            vsync_n  <= !vpulse;
            video_on <= vis;
            rgb      <= (vis && show) ? pix_in : '0;
        end
    end

    a_r5_dark_outside: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en && !vis |=> (rgb == '0) && !video_on);

    a_r8_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en && !show |=> rgb == '0);

endmodule

// File: rtl/vga_upscale_scanout.sv
module vga_upscale_scanout
    import vga_scan_pkg::*;
#(
    parameter int unsigned H_VIS   = 640,
    parameter int unsigned H_FRONT = 16,
    parameter int unsigned H_SYNC  = 96,
    parameter int unsigned H_BACK  = 48,
    parameter int unsigned V_VIS   = 480,
    parameter int unsigned V_FRONT = 10,
    parameter int unsigned V_SYNC  = 2,
    parameter int unsigned V_BACK  = 33,
    parameter int unsigned PIX_W   = 12,
    localparam int unsigned SRC_W  = H_VIS / 2,
    localparam int unsigned SRC_H  = V_VIS / 2,
    localparam int unsigned ADDR_W = width_for(SRC_W * SRC_H),
    localparam int unsigned X_W    = width_for(H_VIS + H_FRONT + H_SYNC + H_BACK),
    localparam int unsigned Y_W    = width_for(V_VIS + V_FRONT + V_SYNC + V_BACK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              show_mode,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              video_on,
    output logic [PIX_W-1:0]  rgb_out
);

    logic [X_W-1:0] col;
    logic [Y_W-1:0] row;
    logic           h_vis, h_pulse, h_wrap;
    logic           v_vis, v_pulse, v_wrap;
    logic           v_step, on_screen;

    assign v_step    = pix_en && h_wrap;
    assign on_screen = h_vis && v_vis;

    vga_axis_fsm #(
        .VIS(H_VIS), .FRONT(H_FRONT), .PULSE(H_SYNC), .BACK(H_BACK)
    ) u_h_axis (
        .clk(clk), .rst_n(rst_n), .step(pix_en),
        .pos(col), .in_vis(h_vis), .in_pulse(h_pulse), .wrap(h_wrap)
    );

    vga_axis_fsm #(
        .VIS(V_VIS), .FRONT(V_FRONT), .PULSE(V_SYNC), .BACK(V_BACK)
    ) u_v_axis (
        .clk(clk), .rst_n(rst_n), .step(v_step),
        .pos(row), .in_vis(v_vis), .in_pulse(v_pulse), .wrap(v_wrap)
    );

    vga_addr_gen #(
        .SRC_W(SRC_W), .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)
    ) u_addr (
        .vis(on_screen), .col(col), .row(row), .addr(rd_addr)
    );

    vga_out_stage #(
        .PIX_W(PIX_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .show(show_mode),
        .vis(on_screen), .hpulse(h_pulse), .vpulse(v_pulse), .pix_in(rd_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .video_on(video_on), .rgb(rgb_out)
    );

    // R7: the memory needs one spare clock between enables
    a_r7_enable_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en);

    a_r6_pair_shares_word: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en && on_screen && !col[0] |=> rd_addr == $past(rd_addr));

    a_r9_frame_end_to_origin: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |=> (col == '0) && (row == '0));

endmodule

// File: tb/vga_upscale_scanout_test.sv
module vga_upscale_scanout_test;

    localparam int HV = 16, HF = 2, HS = 3, HB = 3;
    localparam int VV = 8,  VF = 1, VS = 2, VB = 2;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FT = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        show_mode = 1'b1;
    logic [4:0]  rd_addr;
    logic [11:0] rd_data = '0;
    logic        hsync_n, vsync_n, video_on;
    logic [11:0] rgb_out;

    int tests = 0, fails = 0;
    int n = 0;
    bit shw = 1'b0, en_last = 1'b0, done = 1'b0;
    logic [11:0] prev_rgb = '0;

    always #2 clk = ~clk;

    vga_upscale_scanout #(
        .H_VIS(HV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_VIS(VV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB), .PIX_W(12)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .show_mode(show_mode),
        .rd_addr(rd_addr), .rd_data(rd_data), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .video_on(video_on), .rgb_out(rgb_out)
    );

    function automatic logic [11:0] mem_word(input int a);
        return 12'((a * 37 + 5) ^ (a << 5));
    endfunction
    function automatic int px(input int p); return p % HT; endfunction
    function automatic int py(input int p); return (p / HT) % VT; endfunction
    function automatic bit act(input int p); return px(p) < HV && py(p) < VV; endfunction
    function automatic int addr_of(input int p);
        return act(p) ? (py(p) / 2) * (HV / 2) + px(p) / 2 : 0;
    endfunction
    function automatic bit hs_low(input int p);
        return px(p) >= HV + HF && px(p) < HV + HF + HS;
    endfunction
    function automatic bit vs_low(input int p);
        return py(p) >= VV + VF && py(p) < VV + VF + VS;
    endfunction

    // frame memory with one clock of read latency
    always @(posedge clk) rd_data <= mem_word(int'(rd_addr));

    // reference position counter
    always @(posedge clk) begin
        en_last <= rst_n && pix_en;
        if (!rst_n) n <= 0;
        else if (pix_en) begin
            n   <= n + 1;
            shw <= show_mode;
        end
    end

    task automatic chk(input string tag, input string what, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    task automatic check_outputs();
        int q, p;
        if (n == 0) begin
            chk("R1", "hsync_n", int'(hsync_n), 1);
            chk("R1", "vsync_n", int'(vsync_n), 1);
            chk("R1", "video_on", int'(video_on), 0);
            chk("R1", "rgb_out", int'(rgb_out), 0);
            chk("R1", "rd_addr", int'(rd_addr), 0);
        end else begin
            q = (n - 1) % FT;
            p = n % FT;
            chk("R3", "hsync_n", int'(hsync_n), hs_low(q) ? 0 : 1);
            chk("R4", "vsync_n", int'(vsync_n), vs_low(q) ? 0 : 1);
            if (q == 0 && n > FT)
                chk("R9", "video_on at frame restart", int'(video_on), 1);
            else
                chk("R5", "video_on", int'(video_on), act(q) ? 1 : 0);
            chk("R6", "rd_addr", int'(rd_addr), addr_of(p));
            if (shw)
                chk("R7", "rgb_out", int'(rgb_out), act(q) ? int'(mem_word(addr_of(q))) : 0);
            else
                chk("R8", "rgb_out show off", int'(rgb_out), 0);
            if (!en_last)
                chk("R2", "rgb_out hold", int'(rgb_out), int'(prev_rgb));
        end
        prev_rgb = rgb_out;
    endtask

    initial begin
        int gap = 0;
        bit mid_reset = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_outputs();
        rst_n = 1'b1;
        while (n < 3 * FT + 30) begin
            @(negedge clk);
            check_outputs();
            if (!mid_reset && n >= 2 * FT + 37) begin
                mid_reset = 1'b1;
                pix_en = 1'b0;
                rst_n  = 1'b0;
                repeat (2) begin
                    @(negedge clk);
                    check_outputs();
                end
                rst_n = 1'b1;
                gap   = 1;
            end else if (gap > 0) begin
                pix_en = 1'b0;
                gap--;
            end else begin
                pix_en = 1'b1;
                gap = 1 + int'($urandom_range(0, 2));
                if ($urandom_range(0, 29) == 0) show_mode = ~show_mode;
                if (n > FT && n < FT + 2 * HT) show_mode = 1'b0;
                if (n >= FT + 2 * HT && n < FT + 2 * HT + 3) show_mode = 1'b1;
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired at n=%0d", n);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule